// File: doc/BRIEF.md
# Double-Data-Rate Sample Serializer

This block turns a stream of parallel converter samples into a single serial data line for a double-data-rate link. Each frame lasts exactly `SAMPLE_W` cycles of an internal clock that runs at the serial bit rate, and it carries one whole sample. The least-significant bit goes out first, and one bit is sent per internal clock cycle. A forwarded bit clock toggles on every internal cycle, so it runs at half the bit rate with a 50% duty cycle, and each of its edges marks one data bit. A frame marker is high during the first half of each frame and low during the second half, so it toggles at the sample rate.

Samples arrive on a parallel bus with a one-cycle valid strobe. A sample offered on the clock edge that starts a frame is sent in that frame. A sample that arrives while a frame is in progress is parked in a pending register and sent in the next frame. If nothing new has arrived by a frame boundary, the previous sample is sent again. Sequencing is done by a three-state machine: `ST_HALT` (held by reset), `ST_LEAD` (first half of the frame) and `ST_TRAIL` (second half). The transitions are:

- `ST_HALT -> ST_LEAD` on the first edge with reset low, which starts a frame.
- `ST_LEAD -> ST_TRAIL` after slot `SAMPLE_W/2-1`.
- `ST_TRAIL -> ST_LEAD` after slot `SAMPLE_W-1`, which starts the next frame.
- Any state `-> ST_HALT` on reset.

`SAMPLE_W` must be even and at least 2.

Top module: `ser_frame_tx`

## Requirements
- R1: On a rising clock edge with `rst` high, `ser_data`, `bit_clk` and `frame_mark` become 0 and any pending or current sample is cleared to zero. The first edge with `rst` low starts a frame.
- R2: In slot k of a frame (k = 0 is the cycle after the frame-start edge), `ser_data` carries bit k of that frame's sample, so bit 0 goes first and bit `SAMPLE_W-1` goes last.
- R3: While out of reset, `bit_clk` inverts on every clock cycle. It is 1 in even slots (including slot 0) and 0 in odd slots, which gives a 50% duty cycle at half the bit rate.
- R4: Every frame is exactly `SAMPLE_W` cycles long. `frame_mark` is 1 in slots 0 to `SAMPLE_W/2-1` and 0 in the remaining slots.
- R5: A sample with `smp_valid` high on a frame-start edge is the sample transmitted in the frame that begins at that edge.
- R6: A sample with `smp_valid` high on any other edge does not change the frame in flight. It is transmitted in the next frame, and if several arrive within one frame, the last one wins.
- R7: If no sample is pending and `smp_valid` is low at a frame-start edge, the previous frame's sample is sent again. After reset this is all zeros.
- R8: A sample valid on the frame-start edge takes priority over a pending mid-frame sample, and the pending one is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at the serial bit rate |
| rst | input | 1 | Synchronous reset, active high |
| smp_data | input | SAMPLE_W | Parallel sample word |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| ser_data | output | 1 | Serial data bit, least-significant bit first |
| bit_clk | output | 1 | Forwarded half-rate bit clock |
| frame_mark | output | 1 | High during the first half of each frame |

## Verification
The assertions check on every cycle that the bit clock toggles and that reset silences all three outputs. They also check that each high stretch of the frame marker lasts exactly half a frame, that a frame start yields a high marker and a high bit clock, and that the selected word stays frozen between frame starts. Only the bench's scenarios can show which sample lands in which frame. That covers bit ordering, deferral of mid-frame samples, last-wins replacement, priority at the boundary and repetition when no sample arrives. The bench compares each bit against a sample it tracks itself over an exhaustive sweep of 8-bit words.

// File: rtl/ser_frame_pkg.sv
`timescale 1ns/1ps
package ser_frame_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } frame_state_e;

endpackage

// File: rtl/ser_slot_fsm.sv
`timescale 1ns/1ps
module ser_slot_fsm
    import ser_frame_pkg::*;
#(
    parameter int SLOTS  = 16,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              load_o,
    output logic [SLOT_W-1:0] nxt_slot_o,
    output logic              nxt_lead_o
);

    localparam int HALF = SLOTS / 2;
    localparam logic [SLOT_W-1:0] HALF_END = SLOT_W'(HALF - 1);
    localparam logic [SLOT_W-1:0] LAST     = SLOT_W'(SLOTS - 1);

    frame_state_e      state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              start_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HALT;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        start_d = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                state_d = ST_LEAD;
                slot_d  = '0;
                start_d = 1'b1;
            end
            ST_LEAD: begin
                slot_d = slot_q + SLOT_W'(1);
                if (slot_q == HALF_END) begin
                    state_d = ST_TRAIL;
                end
            end
            ST_TRAIL: begin
                if (slot_q == LAST) begin
                    state_d = ST_LEAD;
                    slot_d  = '0;
                    start_d = 1'b1;
                end else begin
                    slot_d = slot_q + SLOT_W'(1);
                end
            end
            default: begin
                state_d = ST_HALT;
                slot_d  = '0;
            end
        endcase
    end

    // outputs toward the datapath
    always_comb begin
        load_o     = start_d & ~rst;
        nxt_slot_o = slot_d;
        nxt_lead_o = (state_d == ST_LEAD);
    end

endmodule

// File: rtl/ser_sample_hold.sv
`timescale 1ns/1ps
module ser_sample_hold #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] smp_data_i,
    input  logic             smp_valid_i,
    output logic [WIDTH-1:0] word_o
);

    logic [WIDTH-1:0] cur_q, pend_q, chosen;
    logic             pend_vld_q;

    // boundary strobe beats pending word, pending beats repeat
    always_comb begin
        if (smp_valid_i) begin
            chosen = smp_data_i;
        end else if (pend_vld_q) begin
            chosen = pend_q;
        end else begin
            chosen = cur_q;
        end
        word_o = load_i ? chosen : cur_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= '0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else if (load_i) begin
            cur_q      <= chosen;
            pend_vld_q <= 1'b0;
        end else if (smp_valid_i) begin
            pend_q     <= smp_data_i;
            pend_vld_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ser_line_out.sv
`timescale 1ns/1ps
module ser_line_out #(
    parameter int WIDTH  = 16,
    parameter int SLOT_W = $clog2(WIDTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIDTH-1:0]  word_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              lead_i,
    output logic              ser_data_o,
    output logic              bit_clk_o,
    output logic              frame_mark_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_data_o   <= 1'b0;
            bit_clk_o    <= 1'b0;
            frame_mark_o <= 1'b0;
        end else begin
            ser_data_o   <= word_i[slot_i];
            bit_clk_o    <= ~bit_clk_o;
            frame_mark_o <= lead_i;
        end
    end

endmodule

// File: rtl/ser_frame_tx.sv
`timescale 1ns/1ps
module ser_frame_tx #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                smp_valid,
    output logic                ser_data,
    output logic                bit_clk,
    output logic                frame_mark
);

    localparam int SLOT_W = $clog2(SAMPLE_W);

    logic                load_w;
    logic [SLOT_W-1:0]   slot_w;
    logic                lead_w;
    logic [SAMPLE_W-1:0] word_w;

    ser_slot_fsm #(.SLOTS(SAMPLE_W), .SLOT_W(SLOT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .load_o     (load_w),
        .nxt_slot_o (slot_w),
        .nxt_lead_o (lead_w)
    );

    ser_sample_hold #(.WIDTH(SAMPLE_W)) u_hold (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load_w),
        .smp_data_i  (smp_data),
        .smp_valid_i (smp_valid),
        .word_o      (word_w)
    );

    ser_line_out #(.WIDTH(SAMPLE_W), .SLOT_W(SLOT_W)) u_out (
        .clk          (clk),
        .rst          (rst),
        .word_i       (word_w),
        .slot_i       (slot_w),
        .lead_i       (lead_w),
        .ser_data_o   (ser_data),
        .bit_clk_o    (bit_clk),
        .frame_mark_o (frame_mark)
    );

endmodule

// File: rtl/ser_frame_tx_chk.sv
`timescale 1ns/1ps
module ser_frame_tx_chk #(
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                ser_data,
    input logic                bit_clk,
    input logic                frame_mark,
    input logic                load_w,
    input logic [SAMPLE_W-1:0] word_w
);

    localparam int CW = $clog2(SAMPLE_W) + 1;

    logic          live     = 1'b0;
    logic          mk_prev  = 1'b0;
    logic          clk_prev = 1'b0;
    logic [CW-1:0] mark_run = '0;

    always_ff @(posedge clk) begin
        live     <= ~rst;
        mk_prev  <= frame_mark;
        clk_prev <= bit_clk;
        if (rst || !frame_mark) begin
            mark_run <= '0;
        end else begin
            mark_run <= mark_run + CW'(1);
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!ser_data && !bit_clk && !frame_mark));                        // R1

    AST_BCLK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        live |-> (bit_clk != clk_prev));                                         // R3

    AST_MARK_HALF: assert property (@(posedge clk) disable iff (rst)
        (live && mk_prev && !frame_mark) |-> (mark_run == CW'(SAMPLE_W / 2)));   // R4

    AST_FRAME_HEAD: assert property (@(posedge clk) disable iff (rst)
        load_w |=> (frame_mark && bit_clk));                                     // R4

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        !load_w |=> (load_w || $stable(word_w)));                                // R6

endmodule

bind ser_frame_tx ser_frame_tx_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ser_data   (ser_data),
    .bit_clk    (bit_clk),
    .frame_mark (frame_mark),
    .load_w     (load_w),
    .word_w     (word_w)
);

// File: tb/ser_frame_tx_tb_top.sv
`timescale 1ns/1ps
module ser_frame_tx_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] smp_data;
    logic         smp_valid;
    logic         ser_data, bit_clk, frame_mark;

    int checks = 0;
    int fails  = 0;

    // expected-state tracking from the requirements
    logic [W-1:0] m_cur, m_pend;
    logic         m_pv, m_halt, m_bclk;
    int           m_slot;

    always #2.5 clk = ~clk;

    ser_frame_tx #(.SAMPLE_W(W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .smp_data   (smp_data),
        .smp_valid  (smp_valid),
        .ser_data   (ser_data),
        .bit_clk    (bit_clk),
        .frame_mark (frame_mark)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_valid = 1'b0;
        @(posedge clk);
        m_cur = '0; m_pend = '0; m_pv = 1'b0; m_halt = 1'b1; m_bclk = 1'b0; m_slot = 0;
        @(negedge clk);
        chk("R1", "ser_data", ser_data, 1'b0);
        chk("R1", "bit_clk", bit_clk, 1'b0);
        chk("R1", "frame_mark", frame_mark, 1'b0);
        rst = 1'b0;
    endtask

    task automatic step(input logic v, input logic [W-1:0] d, input string dreq);
        smp_valid = v;
        smp_data  = d;
        @(posedge clk);
        if (m_halt || m_slot == W - 1) begin
            if (v)         m_cur = d;
            else if (m_pv) m_cur = m_pend;
            m_pv = 1'b0; m_slot = 0; m_halt = 1'b0;
        end else begin
            if (v) begin m_pend = d; m_pv = 1'b1; end
            m_slot++;
        end
        m_bclk = ~m_bclk;
        @(negedge clk);
        smp_valid = 1'b0;
        chk(dreq, "ser_data", ser_data, m_cur[m_slot]);
        chk("R3", "bit_clk", bit_clk, m_bclk);
        chk("R4", "frame_mark", frame_mark, (m_slot < W / 2));
    endtask

    // one frame; a strobe at edge 0 lands on the boundary
    task automatic send_frame(input logic v, input logic [W-1:0] d, input string req);
        step(v, d, req);
        for (int s = 1; s < W; s++) step(1'b0, '0, req);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; smp_valid = 1'b0; smp_data = '0;
        repeat (2) @(negedge clk);
        do_reset();

        // R2 R5: every word, strobed on the frame-start edge
        for (int v = 0; v < (1 << W); v++) send_frame(1'b1, W'(v), "R2 R5");

        // R7: nothing offered, last word repeats
        for (int f = 0; f < 3; f++) send_frame(1'b0, '0, "R7");

        // R6: mid-frame strobe at each position, deferred by one frame
        for (int pos = 1; pos < W; pos++) begin
            for (int s = 0; s < W; s++) step(s == pos, W'(pos * 37 + 5), "R6");
        end
        send_frame(1'b0, '0, "R6");

        // R6: two mid-frame strobes, the later one wins
        for (int s = 0; s < W; s++) begin
            if (s == 2)      step(1'b1, 8'hA5, "R6");
            else if (s == 5) step(1'b1, 8'h3C, "R6");
            else             step(1'b0, '0, "R6");
        end
        send_frame(1'b0, '0, "R6");
        send_frame(1'b0, '0, "R6");

        // R8: boundary strobe overrides pending word, which is dropped
        for (int s = 0; s < W; s++) step(s == 3, 8'h11, "R8");
        send_frame(1'b1, 8'hEE, "R8");
        send_frame(1'b0, '0, "R8");

        // R1: reset mid-frame clears a pending word; R7 repeats zeros
        step(1'b0, '0, "R1");
        step(1'b1, 8'h77, "R1");
        step(1'b0, '0, "R1");
        do_reset();
        send_frame(1'b0, '0, "R7");
        send_frame(1'b0, '0, "R7");

        summary();
        $finish;
    end

endmodule